// File: doc/BRIEF.md
# Program Memory Region Mode Decoder

This block routes each program-space access made by a processor core. For every request it takes a 21-bit byte address and decides whether the access is served by on-chip flash or by the external memory bus. The decision depends on a 2-bit memory mode, two elaboration-time limits, and a bus-disable control bit. The limits are the last address of the boot region and the last address of on-chip memory.

The decision is registered one clock after the request strobe and comes with a valid flag. The outputs are:

- an external-select flag;
- a zero-fill flag, which tells the fetch path to substitute an all-zero word for reads that fall above on-chip memory in internal-only mode;
- a chip-enable request for the external device;
- a 2-bit pin-ownership code for the pad multiplexer. It either hands the shared pins to general I/O, parks the bus (address/data floating, strobes at their idle levels), or lets the bus sequencer drive them.

The block does not contain the flash array, the bus timing sequencer or the pad drivers. An elaboration check rejects a boot limit that is not below the on-chip limit.

Top module: `pmem_region_decoder`

## Requirements
- R1: With mode 2'b11 (internal-only), every access decides internal: external-select 0, chip-enable request 0, pin code 2'b00 (general I/O), whatever the address or the bus-disable bit.
- R2: With mode 2'b11, an address above INT_LAST gives zero-fill 1; an address at or below INT_LAST gives zero-fill 0. In every other mode zero-fill is 0.
- R3: With mode 2'b10 (external-only), every address from 0x000000 to 0x1FFFFF decides external.
- R4: With mode 2'b01 (boot region plus external), addresses at or below BOOT_LAST decide internal and all higher addresses decide external.
- R5: With mode 2'b00 (extended), addresses at or below INT_LAST decide internal and all higher addresses decide external.
- R6: The chip-enable request is 1 exactly when the decision is external.
- R7: The pin code depends on the decision and the bus-disable bit:
  - An external decision gives 2'b10 (bus driven).
  - An internal decision in modes 2'b00, 2'b01 and 2'b10 gives 2'b00 (general I/O) when bus-disable is 1.
  - An internal decision in those modes gives 2'b01 (bus parked: address/data floating, output-enable, write, chip-enable and byte-enable strobes high, latch-enable and byte-address low) when bus-disable is 0.
- R8: The bus-disable bit has no effect on any output when the decision is external or the mode is 2'b11.
- R9: The decision outputs change only on the clock edge that samples the request strobe high. On the next cycle, valid is 1 after a cycle with the strobe high and 0 after a cycle with it low; with the strobe low the decision outputs hold their values.
- R10: Under reset, valid, external-select, zero-fill and chip-enable request are 0 and the pin code is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Access request strobe |
| addr_i | input | 21 | Program-space byte address |
| mode_i | input | 2 | Memory mode (00 extended, 01 boot+external, 10 external-only, 11 internal-only) |
| bus_off_i | input | 1 | Bus-disable bit, honoured only for internal decisions in external-capable modes |
| dec_valid_o | output | 1 | Decision valid, one cycle after each request |
| sel_ext_o | output | 1 | Access goes to external bus |
| zero_fill_o | output | 1 | Return all-zero data for this read |
| ce_req_o | output | 1 | Request to assert the external chip enable |
| pin_own_o | output | 2 | Shared pin ownership: 00 I/O, 01 bus parked, 10 bus driven |

## Verification
Every result of this block is due exactly one clock after the edge that samples the request strobe; nothing is combinational from the inputs. The bench drives a request on a falling edge and releases it on the next falling edge. It then reads all five outputs at that falling edge, half a cycle after the rising edge that loaded them. The hold checks change the address and mode while the strobe is low and read the outputs one further falling edge later. By then a decoder that ignored the strobe would already have moved.

// File: rtl/pmem_region_pkg.sv
// Package: shared types for the program memory region decoder.
// Assumes a 2-bit mode field whose encoding is fixed by the core's mode setting.
package pmem_region_pkg;

    typedef enum logic [1:0] {
        MODE_EXTENDED = 2'b00,   // on-chip up to INT_LAST, external above
        MODE_BOOT_EXT = 2'b01,   // on-chip up to BOOT_LAST, external above
        MODE_EXT_ONLY = 2'b10,   // everything external
        MODE_INT_ONLY = 2'b11    // everything on-chip, zero fill above INT_LAST
    } mem_mode_e;

    typedef enum logic [1:0] {
        PIN_PORT_IO  = 2'b00,    // shared pins given to general I/O
        PIN_BUS_PARK = 2'b01,    // bus owns pins, floating data, strobes idle
        PIN_BUS_LIVE = 2'b10     // bus sequencer drives the pins
    } pin_own_e;

    typedef struct packed {
        logic     ext;
        logic     zero;
        logic     ce;
        pin_own_e pin;
    } route_t;

    localparam route_t ROUTE_RESET = '{ext: 1'b0, zero: 1'b0, ce: 1'b0, pin: PIN_PORT_IO};

endpackage

// File: rtl/pmem_limit_cmp.sv
// Module: unsigned "address above limit" comparator.
// Assumes LIMIT fits in ADDR_W bits; output is purely combinational.
module pmem_limit_cmp #(
    parameter int               ADDR_W = 21,
    parameter logic [ADDR_W-1:0] LIMIT = '0
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              above_o
);
    // Compare the address against the fixed limit.
    always_comb begin
        above_o = (addr_i > LIMIT);
    end
endmodule

// File: rtl/pmem_route_logic.sv
// Module: combinational routing decision from mode, region flags and bus-disable.
// Assumes above_boot implies above_int is never true without above_boot
// (BOOT_LAST < INT_LAST), which the top checks at elaboration.
module pmem_route_logic
    import pmem_region_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       above_boot_i,
    input  logic       above_int_i,
    input  logic       bus_off_i,
    output route_t     route_o
);
    mem_mode_e mode;
    logic      go_ext;

    // Cast the raw mode field to its enumerated meaning.
    always_comb begin
        mode = mem_mode_e'(mode_i);
    end

    // Pick the target memory for the given mode.
    always_comb begin
        unique case (mode)
            MODE_EXTENDED: go_ext = above_int_i;
            MODE_BOOT_EXT: go_ext = above_boot_i;
            MODE_EXT_ONLY: go_ext = 1'b1;
            default:       go_ext = 1'b0;
        endcase
    end

    // Build the full decision: select, zero fill, chip enable, pin ownership.
    always_comb begin
        route_o.ext  = go_ext;
        route_o.ce   = go_ext;
        route_o.zero = (mode == MODE_INT_ONLY) && above_int_i;
        if (mode == MODE_INT_ONLY) begin
            route_o.pin = PIN_PORT_IO;
        end else if (go_ext) begin
            route_o.pin = PIN_BUS_LIVE;
        end else if (bus_off_i) begin
            route_o.pin = PIN_PORT_IO;
        end else begin
            route_o.pin = PIN_BUS_PARK;
        end
    end
endmodule

// File: rtl/pmem_decision_reg.sv
// Module: holds the routing decision, loaded on each request strobe.
// Assumes synchronous active-low reset; outputs keep their value between requests.
module pmem_decision_reg
    import pmem_region_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_i,
    input  route_t route_i,
    output logic   valid_o,
    output route_t route_o
);
    // Load the decision on a request and flag it valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            route_o <= ROUTE_RESET;
        end else begin
            valid_o <= req_i;
            if (req_i) begin
                route_o <= route_i;
            end
        end
    end

    // R9: without a request the stored decision must not move.
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> $stable(route_o));
endmodule

// File: rtl/pmem_region_decoder.sv
// Module: top of the program memory region decoder.
// Decides per request whether an access is on-chip or external, whether it
// reads as zero, whether the external chip enable is wanted and who owns the
// shared pins. Assumes BOOT_LAST < INT_LAST < 2**ADDR_W.
module pmem_region_decoder
    import pmem_region_pkg::*;
#(
    parameter int                ADDR_W    = 21,
    parameter logic [ADDR_W-1:0] BOOT_LAST = 21'h0007FF,
    parameter logic [ADDR_W-1:0] INT_LAST  = 21'h00FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        mode_i,
    input  logic              bus_off_i,
    output logic              dec_valid_o,
    output logic              sel_ext_o,
    output logic              zero_fill_o,
    output logic              ce_req_o,
    output logic [1:0]        pin_own_o
);
    localparam int N_LIMITS = 2;
    localparam logic [ADDR_W-1:0] LIMITS [N_LIMITS] = '{BOOT_LAST, INT_LAST};

    logic [N_LIMITS-1:0] above;
    route_t              route_next;
    route_t              route_q;

    // Elaboration-time check on the limit ordering.
    initial begin
        p_param_order: assert (BOOT_LAST < INT_LAST)
            else $error("pmem_region_decoder: BOOT_LAST must be below INT_LAST");
    end

    // One comparator per region limit.
    for (genvar i = 0; i < N_LIMITS; i++) begin : g_cmp
        pmem_limit_cmp #(
            .ADDR_W (ADDR_W),
            .LIMIT  (LIMITS[i])
        ) u_cmp (
            .addr_i  (addr_i),
            .above_o (above[i])
        );
    end

    pmem_route_logic u_route (
        .mode_i       (mode_i),
        .above_boot_i (above[0]),
        .above_int_i  (above[1]),
        .bus_off_i    (bus_off_i),
        .route_o      (route_next)
    );

    pmem_decision_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .route_i (route_next),
        .valid_o (dec_valid_o),
        .route_o (route_q)
    );

    // Drive the ports from the stored decision.
    always_comb begin
        sel_ext_o   = route_q.ext;
        zero_fill_o = route_q.zero;
        ce_req_o    = route_q.ce;
        pin_own_o   = route_q.pin;
    end

    // R1: internal-only mode never selects the bus and leaves pins to I/O.
    p_int_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && mode_i == 2'b11) |=> (!sel_ext_o && !ce_req_o && pin_own_o == 2'b00));
    // R3: external-only mode always selects the bus.
    p_ext_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && mode_i == 2'b10) |=> sel_ext_o);
    // R2: zero fill never accompanies an external decision.
    p_zero_internal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && zero_fill_o) |-> !sel_ext_o);
    // R6: chip enable request matches the external decision.
    p_ce_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_o |-> (ce_req_o == sel_ext_o));
    // R7: an external decision always drives the bus pins.
    p_live_pins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && sel_ext_o) |-> (pin_own_o == 2'b10));
    // R9: valid follows the request strobe by exactly one cycle.
    p_valid_on_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> dec_valid_o);
    p_valid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !dec_valid_o);
endmodule

// File: tb/pmem_region_decoder_bench.sv
module pmem_region_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [20:0] addr_i = '0;
    logic [1:0]  mode_i = 2'b00;
    logic        bus_off_i = 1'b0;
    logic        dec_valid_o, sel_ext_o, zero_fill_o, ce_req_o;
    logic [1:0]  pin_own_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #10 clk = ~clk;   // 50 MHz

    pmem_region_decoder u_pmem_region_decoder (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i),
        .mode_i(mode_i), .bus_off_i(bus_off_i), .dec_valid_o(dec_valid_o),
        .sel_ext_o(sel_ext_o), .zero_fill_o(zero_fill_o), .ce_req_o(ce_req_o),
        .pin_own_o(pin_own_o)
    );

    // Vector layout: {mode[2], bus_off, addr[21], ext, zero, pin[2]}.
    // Limits are the defaults: boot 0x0007FF, on-chip 0x00FFFF.
    localparam int NV = 14;
    localparam logic [27:0] VEC [NV] = '{
        {2'b11, 1'b0, 21'h000000, 1'b0, 1'b0, 2'b00},  // R1
        {2'b11, 1'b1, 21'h00FFFF, 1'b0, 1'b0, 2'b00},  // R1 top of on-chip
        {2'b11, 1'b0, 21'h010000, 1'b0, 1'b1, 2'b00},  // R2 first unmapped
        {2'b11, 1'b1, 21'h1FFFFF, 1'b0, 1'b1, 2'b00},  // R2 top of space
        {2'b10, 1'b1, 21'h000000, 1'b1, 1'b0, 2'b10},  // R3 bottom
        {2'b10, 1'b0, 21'h1FFFFF, 1'b1, 1'b0, 2'b10},  // R8 bus-off ignored
        {2'b01, 1'b1, 21'h0007FF, 1'b0, 1'b0, 2'b00},  // R4 boot edge
        {2'b01, 1'b0, 21'h0007FF, 1'b0, 1'b0, 2'b01},  // R7 parked
        {2'b01, 1'b1, 21'h000800, 1'b1, 1'b0, 2'b10},  // R4 above boot
        {2'b00, 1'b0, 21'h00FFFF, 1'b0, 1'b0, 2'b01},  // R5 on-chip edge
        {2'b00, 1'b1, 21'h00FFFF, 1'b0, 1'b0, 2'b00},  // R7 I/O
        {2'b00, 1'b1, 21'h010000, 1'b1, 1'b0, 2'b10},  // R8 bus-off ignored
        {2'b00, 1'b0, 21'h1FFFFF, 1'b1, 1'b0, 2'b10},  // R5 top
        {2'b01, 1'b0, 21'h00FFFF, 1'b1, 1'b0, 2'b10}   // R4 above boot
    };
    localparam int VTAG [NV] = '{1, 1, 2, 2, 3, 8, 4, 7, 4, 5, 7, 8, 5, 4};

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] m, input logic b, input logic [20:0] a);
        @(negedge clk);
        mode_i = m; bus_off_i = b; addr_i = a; req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 5000);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 valid", dec_valid_o, 0);
        check("R10 ext", sel_ext_o, 0);
        check("R10 zero", zero_fill_o, 0);
        check("R10 ce", ce_req_o, 0);
        check("R10 pin", pin_own_o, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            string t;
            issue(VEC[i][27:26], VEC[i][25], VEC[i][24:4]);
            t = $sformatf("R%0d vec%0d", VTAG[i], i);
            check({t, " valid"}, dec_valid_o, 1);
            check({t, " ext"}, sel_ext_o, VEC[i][3]);
            check({t, " zero"}, zero_fill_o, VEC[i][2]);
            check({t, " pin"}, pin_own_o, VEC[i][1:0]);
            check({"R6 ", t, " ce"}, ce_req_o, VEC[i][3]);
        end

        // R9: hold with strobe low while inputs move
        issue(2'b10, 1'b0, 21'h123456 & 21'h1FFFFF);
        mode_i = 2'b11; addr_i = 21'h020000; bus_off_i = 1'b1;
        @(negedge clk);
        check("R9 idle valid", dec_valid_o, 0);
        check("R9 hold ext", sel_ext_o, 1);
        check("R9 hold zero", zero_fill_o, 0);
        check("R9 hold pin", pin_own_o, 2);

        // R9: back-to-back requests each get their own decision
        @(negedge clk);
        mode_i = 2'b01; bus_off_i = 1'b0; addr_i = 21'h000000; req_i = 1'b1;
        @(negedge clk);
        check("R9 b2b first valid", dec_valid_o, 1);
        check("R9 b2b first pin", pin_own_o, 1);
        addr_i = 21'h000800;
        @(negedge clk);
        req_i = 1'b0;
        check("R9 b2b second valid", dec_valid_o, 1);
        check("R9 b2b second ext", sel_ext_o, 1);

        // R2: zero fill then a mode change clears it
        issue(2'b11, 1'b0, 21'h1F0000);
        check("R2 zero set", zero_fill_o, 1);
        issue(2'b00, 1'b0, 21'h1F0000);
        check("R2 zero other mode", zero_fill_o, 0);

        // R10: reset in the middle of a run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 mid ext", sel_ext_o, 0);
        check("R10 mid ce", ce_req_o, 0);
        check("R10 mid pin", pin_own_o, 0);
        rst_n = 1'b1;

        finish_run();
    end
endmodule